// File: doc/BRIEF.md
# Table Pointer and Byte Latch Unit

This block moves one byte at a time between a program memory organised as 16-bit words and an 8-bit data path. It keeps a 22-bit byte address and an 8-bit transfer latch. Software reaches both through a small register port. The pointer appears there as three byte-wide registers: low, middle and upper.

A table read command fetches the word that holds the addressed byte and keeps that byte in the latch. A table write command sends the latched byte, with its word address and byte lane, to the memory write port. Every command carries a pointer update mode: hold, increment after, decrement after, or increment before. The arithmetic wraps inside the low 21 bits. Pointer bit 21 selects the configuration space, and no update ever changes it.

Top module: `tbl_byte_port`

## Requirements
- R1: After reset the pointer and the latch are zero, and `busy` and `mem_req` are low.
- R2: `reg_sel` picks a register: 0 = pointer bits 7:0, 1 = pointer bits 15:8, 2 = pointer bits 21:16, 3 = latch. A write is readable on `reg_rdata` one clock later. Selector 2 keeps only `reg_wdata[5:0]` and reads back zero in bits 7:6.
- R3: `cmd_mode` gives the pointer value after a command: 0 leaves it unchanged, 1 adds one, 2 subtracts one, 3 adds one.
- R4: Mode 3 accesses the incremented pointer; modes 0, 1 and 2 access the old pointer. `mem_addr` carries bits 21:1 of the access pointer and `mem_lane` carries bit 0.
- R5: Increment and decrement act modulo 2^21 on bits 20:0: 0x1FFFFF steps up to 0, and 0 steps down to 0x1FFFFF. Bit 21 is never changed by an update.
- R6: When a read completes, the latch takes `mem_rdata[15:8]` if the lane is 1 and `mem_rdata[7:0]` if the lane is 0.
- R7: A write command drives `mem_we` high and presents the latch on `mem_wdata` while `mem_req` is high.
- R8: `mem_req` and `busy` go high in the clock after a command is accepted. Address, lane and write flag stay stable until the cycle in which `mem_valid` is high. Both drop on the following clock, when the new pointer becomes visible.
- R9: `cmd_valid` is ignored while `busy` is high; no second access follows.
- R10: Register writes are ignored while `busy` is high and in the cycle in which a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| cmd_valid | input | 1 | Table command strobe |
| cmd_write | input | 1 | 1 = table write, 0 = table read |
| cmd_mode | input | 2 | Pointer update mode |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 21 | Memory word address |
| mem_lane | output | 1 | Byte lane within the word |
| mem_wdata | output | 8 | Byte to be written |
| mem_valid | input | 1 | Memory read data ready or write acknowledge |
| mem_rdata | input | 16 | Memory read word |

## Verification
A wrong access pointer shows up on `mem_addr` and `mem_lane` in the first cycle of the request. A wrong pending pointer shows up on the register read port one clock after `mem_valid`. A lost or flipped bit 21 appears at once in the upper pointer register. Mixed-up lanes leave a wrong byte in the latch, which is visible right after a read completes. A leak through the busy gate is found by reading the pointer back after the command ends. Pointer values at the wrap edges, with bit 21 both clear and set, are swept through every mode and both directions.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD     = 2'd0,
    MODE_POST_INC = 2'd1,
    MODE_POST_DEC = 2'd2,
    MODE_PRE_INC  = 2'd3
  } ptr_mode_e;

  typedef enum logic [1:0] {
    SEL_PTR_LO  = 2'd0,
    SEL_PTR_MID = 2'd1,
    SEL_PTR_UP  = 2'd2,
    SEL_LATCH   = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/tbl_ptr_math.sv
// Step the pointer up or down within its arithmetic field; the space-select MSB passes through.
module tbl_ptr_math #(
  parameter int PTR_W = 22
) (
  input  logic [PTR_W-1:0] ptr_i,
  output logic [PTR_W-1:0] ptr_inc_o,
  output logic [PTR_W-1:0] ptr_dec_o
);
  localparam int ARITH_W = PTR_W - 1;
  localparam logic [ARITH_W-1:0] ONE = ARITH_W'(1);

  logic [ARITH_W-1:0] low_inc;
  logic [ARITH_W-1:0] low_dec;

  always_comb begin
    low_inc   = ptr_i[ARITH_W-1:0] + ONE;
    low_dec   = ptr_i[ARITH_W-1:0] - ONE;
    ptr_inc_o = {ptr_i[PTR_W-1], low_inc};
    ptr_dec_o = {ptr_i[PTR_W-1], low_dec};
  end
endmodule

// File: rtl/tbl_lane_mux.sv
// Pick one byte lane out of a memory word.
module tbl_lane_mux #(
  parameter int MEM_W  = 16,
  parameter int DATA_W = 8,
  localparam int LANES  = MEM_W / DATA_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [MEM_W-1:0]  word_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [DATA_W-1:0] byte_o
);
  logic [DATA_W-1:0] lane_bytes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = word_i[g*DATA_W +: DATA_W];
  end

  assign byte_o = lane_bytes[lane_i];
endmodule

// File: rtl/tbl_regs.sv
// Pointer byte registers and the transfer latch, with their read mux.
module tbl_regs
  import tbl_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_load_val,
  input  logic              latch_load,
  input  logic [DATA_W-1:0] latch_load_val,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [DATA_W-1:0] latch_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int UP_W  = PTR_W - 2*DATA_W;
  localparam int PAD_W = DATA_W - UP_W;

  logic [PTR_W-1:0]  ptr_d;
  logic [DATA_W-1:0] latch_d;
  logic              ptr_en;
  logic              latch_en;

  always_comb begin
    ptr_d    = ptr_q;
    latch_d  = latch_q;
    ptr_en   = 1'b0;
    latch_en = 1'b0;
    if (ptr_load) begin
      ptr_d  = ptr_load_val;
      ptr_en = 1'b1;
    end else if (wr_en) begin
      unique case (sel)
        SEL_PTR_LO: begin
          ptr_d[DATA_W-1:0] = wdata;
          ptr_en = 1'b1;
        end
        SEL_PTR_MID: begin
          ptr_d[2*DATA_W-1:DATA_W] = wdata;
          ptr_en = 1'b1;
        end
        SEL_PTR_UP: begin
          ptr_d[PTR_W-1:2*DATA_W] = wdata[UP_W-1:0];
          ptr_en = 1'b1;
        end
        default: begin
          latch_d  = wdata;
          latch_en = 1'b1;
        end
      endcase
    end
    if (latch_load) begin
      latch_d  = latch_load_val;
      latch_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_PTR_LO:  rdata = ptr_q[DATA_W-1:0];
      SEL_PTR_MID: rdata = ptr_q[2*DATA_W-1:DATA_W];
      SEL_PTR_UP:  rdata = {{PAD_W{1'b0}}, ptr_q[PTR_W-1:2*DATA_W]};
      default:     rdata = latch_q;
    endcase
  end
endmodule

// File: rtl/tbl_cmd_ctrl.sv
// Command sequencer: captures the access pointer and the pending pointer when a command is accepted,
// holds the memory request, and commits both on the response.
module tbl_cmd_ctrl
  import tbl_pkg::*;
#(
  parameter int PTR_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  ptr_mode_e        cmd_mode,
  input  logic [PTR_W-1:0] ptr_q,
  input  logic [PTR_W-1:0] ptr_inc,
  input  logic [PTR_W-1:0] ptr_dec,
  input  logic             mem_valid,
  output logic             busy,
  output logic             accept,
  output logic             mem_we,
  output logic [PTR_W-1:0] acc_ptr,
  output logic             ptr_load,
  output logic [PTR_W-1:0] ptr_load_val,
  output logic             latch_load
);
  ctrl_state_e      state_q, state_d;
  logic [PTR_W-1:0] acc_q, acc_d;
  logic [PTR_W-1:0] pend_q, pend_d;
  logic             we_q, we_d;

  always_comb begin
    state_d = state_q;
    acc_d   = acc_q;
    pend_d  = pend_q;
    we_d    = we_q;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          accept  = 1'b1;
          state_d = ST_ACCESS;
          we_d    = cmd_write;
          unique case (cmd_mode)
            MODE_HOLD: begin
              acc_d  = ptr_q;
              pend_d = ptr_q;
            end
            MODE_POST_INC: begin
              acc_d  = ptr_q;
              pend_d = ptr_inc;
            end
            MODE_POST_DEC: begin
              acc_d  = ptr_q;
              pend_d = ptr_dec;
            end
            default: begin
              acc_d  = ptr_inc;
              pend_d = ptr_inc;
            end
          endcase
        end
      end
      default: begin
        if (mem_valid) begin
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pend_q <= '0;
      we_q   <= 1'b0;
    end else if (accept) begin
      acc_q  <= acc_d;
      pend_q <= pend_d;
      we_q   <= we_d;
    end
  end

  assign busy         = (state_q == ST_ACCESS);
  assign mem_we       = we_q;
  assign acc_ptr      = acc_q;
  assign ptr_load     = busy && mem_valid;
  assign ptr_load_val = pend_q;
  assign latch_load   = busy && mem_valid && !we_q;
endmodule

// File: rtl/tbl_byte_port.sv
module tbl_byte_port
  import tbl_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int DATA_W = 8,
  parameter int MEM_W  = 16,
  localparam int LANE_W = $clog2(MEM_W / DATA_W),
  localparam int WADR_W = PTR_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_mode,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WADR_W-1:0] mem_addr,
  output logic [LANE_W-1:0] mem_lane,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_valid,
  input  logic [MEM_W-1:0]  mem_rdata
);
  // Reset is asserted asynchronously and released in step with the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_inc;
  logic [PTR_W-1:0]  ptr_dec;
  logic [PTR_W-1:0]  acc_ptr;
  logic [PTR_W-1:0]  ptr_load_val;
  logic [DATA_W-1:0] latch_q;
  logic [DATA_W-1:0] lane_byte;
  logic              ptr_load;
  logic              latch_load;
  logic              accept;
  logic              reg_wr_ok;

  tbl_ptr_math #(.PTR_W(PTR_W)) u_math (
    .ptr_i    (ptr_q),
    .ptr_inc_o(ptr_inc),
    .ptr_dec_o(ptr_dec)
  );

  tbl_cmd_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .cmd_mode    (ptr_mode_e'(cmd_mode)),
    .ptr_q       (ptr_q),
    .ptr_inc     (ptr_inc),
    .ptr_dec     (ptr_dec),
    .mem_valid   (mem_valid),
    .busy        (busy),
    .accept      (accept),
    .mem_we      (mem_we),
    .acc_ptr     (acc_ptr),
    .ptr_load    (ptr_load),
    .ptr_load_val(ptr_load_val),
    .latch_load  (latch_load)
  );

  tbl_lane_mux #(.MEM_W(MEM_W), .DATA_W(DATA_W)) u_lane (
    .word_i(mem_rdata),
    .lane_i(acc_ptr[LANE_W-1:0]),
    .byte_o(lane_byte)
  );

  // Software writes lose to an accepted command and are shut out during an access.
  assign reg_wr_ok = reg_wr_en && !busy && !accept;

  tbl_regs #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .wr_en         (reg_wr_ok),
    .sel           (reg_sel_e'(reg_sel)),
    .wdata         (reg_wdata),
    .ptr_load      (ptr_load),
    .ptr_load_val  (ptr_load_val),
    .latch_load    (latch_load),
    .latch_load_val(lane_byte),
    .ptr_q         (ptr_q),
    .latch_q       (latch_q),
    .rdata         (reg_rdata)
  );

  assign mem_req   = busy;
  assign mem_addr  = acc_ptr[PTR_W-1:LANE_W];
  assign mem_lane  = acc_ptr[LANE_W-1:0];
  assign mem_wdata = latch_q;
endmodule

// File: rtl/tbl_byte_port_chk.sv
module tbl_byte_port_chk #(
  parameter int PTR_W  = 22,
  parameter int DATA_W = 8,
  parameter int WADR_W = 21,
  parameter int LANE_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [WADR_W-1:0] mem_addr,
  input logic [LANE_W-1:0] mem_lane,
  input logic              mem_valid,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [DATA_W-1:0] latch_q
);
  // R2: the unused upper bits of the top pointer register always read zero
  p_upper_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd2) |-> (reg_rdata[DATA_W-1:PTR_W-2*DATA_W] == '0));

  // R8: the request holds steady until the response arrives
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_lane) && $stable(mem_we)));

  // R8: busy ends one clock after the response
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_valid) |=> !busy);

  // R5: a pointer update never alters the space-select bit
  p_space_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_valid) |=> (ptr_q[PTR_W-1] == $past(ptr_q[PTR_W-1])));

  // R10: no register changes while an access waits for its response
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_valid) |=> ($stable(ptr_q) && $stable(latch_q)));
endmodule

bind tbl_byte_port tbl_byte_port_chk #(
  .PTR_W(PTR_W), .DATA_W(DATA_W), .WADR_W(WADR_W), .LANE_W(LANE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_sel  (reg_sel),
  .reg_rdata(reg_rdata),
  .busy     (busy),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_lane (mem_lane),
  .mem_valid(mem_valid),
  .ptr_q    (ptr_q),
  .latch_q  (latch_q)
);

// File: tb/sim_tbl_byte_port.sv
module sim_tbl_byte_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        cmd_valid;
  logic        cmd_write;
  logic [1:0]  cmd_mode;
  logic        busy;
  logic        mem_req;
  logic        mem_we;
  logic [20:0] mem_addr;
  logic [0:0]  mem_lane;
  logic [7:0]  mem_wdata;
  logic        mem_valid;
  logic [15:0] mem_rdata;

  int n_chk = 0;
  int n_err = 0;
  logic [21:0] m_ptr;
  logic [7:0]  m_lat;

  always #4 clk = ~clk;

  tbl_byte_port u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_mode(cmd_mode), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_lane(mem_lane),
    .mem_wdata(mem_wdata), .mem_valid(mem_valid), .mem_rdata(mem_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic [20:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + a[7:0] + 8'h13};
  endfunction

  function automatic logic [21:0] f_inc(input logic [21:0] p);
    return {p[21], p[20:0] + 21'd1};
  endfunction

  function automatic logic [21:0] f_dec(input logic [21:0] p);
    return {p[21], p[20:0] - 21'd1};
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] sel, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_sel = sel;
    #1;
    check(req, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  task automatic set_ptr(input logic [21:0] p);
    wr_reg(2'd0, p[7:0]);
    wr_reg(2'd1, p[15:8]);
    wr_reg(2'd2, {2'b11, p[21:16]});   // top bits written as ones, must be dropped
    m_ptr = p;
  endtask

  task automatic chk_state(input string req);
    rd_chk(2'd0, m_ptr[7:0], req);
    rd_chk(2'd1, m_ptr[15:8], req);
    rd_chk(2'd2, {2'b00, m_ptr[21:16]}, req);
    rd_chk(2'd3, m_lat, req);
  endtask

  // One table command; 'disturb' drives a register write and a second command mid-access.
  task automatic run_cmd(input logic wr, input logic [1:0] mode, input int delay,
                         input logic disturb, input logic same_cycle_wr);
    logic [21:0] acc;
    logic [21:0] nxt;
    logic [15:0] w;
    acc = (mode == 2'd3) ? f_inc(m_ptr) : m_ptr;
    case (mode)
      2'd0: nxt = m_ptr;
      2'd1: nxt = f_inc(m_ptr);
      2'd2: nxt = f_dec(m_ptr);
      default: nxt = f_inc(m_ptr);
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_mode = mode;
    if (same_cycle_wr) begin
      reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = ~m_ptr[7:0];
    end
    @(negedge clk);
    cmd_valid = 1'b0; reg_wr_en = 1'b0;
    check("R8 busy after accept", {31'h0, busy}, 32'h1);
    check("R8 req after accept", {31'h0, mem_req}, 32'h1);
    check("R4 word address", {11'h0, mem_addr}, {11'h0, acc[21:1]});
    check("R4 byte lane", {31'h0, mem_lane}, {31'h0, acc[0]});
    check("R7 write flag", {31'h0, mem_we}, {31'h0, wr});
    if (wr) check("R7 write data", {24'h0, mem_wdata}, {24'h0, m_lat});
    for (int k = 0; k < delay; k++) begin
      if (disturb && k == 0) begin
        cmd_valid = 1'b1; cmd_mode = 2'd1;
        reg_wr_en = 1'b1; reg_sel = 2'd3; reg_wdata = ~m_lat;
      end
      @(negedge clk);
      cmd_valid = 1'b0; reg_wr_en = 1'b0;
      check("R8 request held", {31'h0, mem_req}, 32'h1);
      check("R8 address held", {11'h0, mem_addr}, {11'h0, acc[21:1]});
    end
    w = word_of(acc[21:1]);
    mem_valid = 1'b1; mem_rdata = w;
    @(negedge clk);
    mem_valid = 1'b0; mem_rdata = 16'hDEAD;
    check("R8 busy released", {31'h0, busy}, 32'h0);
    if (!wr) m_lat = acc[0] ? w[15:8] : w[7:0];
    m_ptr = nxt;
    @(negedge clk);
    if (disturb) check("R9 no second access", {31'h0, mem_req}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [21:0] pats [12];
    pats = '{22'h000000, 22'h000001, 22'h000002, 22'h1FFFFF, 22'h1FFFFE, 22'h200000,
             22'h3FFFFF, 22'h3FFFFE, 22'h2ABCDE, 22'h012345, 22'h0FFFFF, 22'h200001};
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_mode = 2'd0;
    mem_valid = 1'b0; mem_rdata = 16'h0000;
    m_ptr = '0; m_lat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 busy at reset", {31'h0, busy}, 32'h0);
    check("R1 req at reset", {31'h0, mem_req}, 32'h0);
    chk_state("R1 registers at reset");

    // R2 register port, including upper padding
    set_ptr(22'h2A5C33);
    wr_reg(2'd3, 8'hC6); m_lat = 8'hC6;
    chk_state("R2 register write/read");

    // R3 R4 R5 R6 R7 sweep over pointer corners, modes and directions
    for (int i = 0; i < 12; i++) begin
      for (int md = 0; md < 4; md++) begin
        for (int op = 0; op < 2; op++) begin
          set_ptr(pats[i]);
          if (op == 1) begin
            wr_reg(2'd3, pats[i][7:0] ^ 8'h3C);
            m_lat = pats[i][7:0] ^ 8'h3C;
          end
          run_cmd(op[0], md[1:0], (i + md + op) % 3, ((i + md) % 3) == 1 && ((i + md + op) % 3) != 0, 1'b0);
          chk_state("R3 R5 R6 R9 R10 pointer and latch after command");
        end
      end
    end

    // R10 register write in the accepting cycle is dropped
    set_ptr(22'h000010);
    run_cmd(1'b0, 2'd1, 1, 1'b0, 1'b1);
    chk_state("R10 same-cycle register write ignored");

    // R5 repeated stepping across wrap with space bit set
    set_ptr(22'h3FFFFE);
    for (int s = 0; s < 4; s++) run_cmd(1'b0, 2'd3, 0, 1'b0, 1'b0);
    chk_state("R5 wrap with space bit set");
    for (int s = 0; s < 4; s++) run_cmd(1'b0, 2'd2, 0, 1'b0, 1'b0);
    chk_state("R5 wrap back downward");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule